// File: doc/BRIEF.md
# Coprocessor Execute Core with Loop Counter and Branch Resolution

This block is the execute stage of a small 16-bit coprocessor. It holds four 16-bit general registers, an 8-bit loop stage counter and two ALU flags (zero and overflow). Each cycle it may accept one decoded operation. The operation carries an opcode, a condition code, register selects, an immediate, a signed byte step and the address of the operation itself. Arithmetic, logic, shift and move operations write a destination register and refresh the flags. Stage operations clear, raise or lower the loop counter.

Branch operations write no state. The core resolves them in the same cycle and reports the address of the next operation to execute. There are three kinds of branch. An absolute jump can be unconditional or can depend on a flag. A relative branch can compare R0 with a threshold. A second relative branch can compare the stage counter with a threshold. The fetch stage that surrounds the core feeds `next_pc` back as the following `cur_pc`. Register state, flags and the stage counter are visible on output buses, so a neighbouring unit can observe them.

Top module: `cop_exec_core`

## Requirements
- R1: While `rst_n` is low, and after it is released, all four registers, the stage counter and both flags read 0.
- R2: With `op_valid` high, opcode 1 (add) and opcode 2 (subtract) write `src1 + opb` or `src1 - opb` modulo 2^16 into register `dst_sel` at the clock edge. Here `opb` is `imm` when `use_imm` is 1 and register `src2_sel` otherwise.
- R3: The flags change only on opcodes 1 to 7. The zero flag becomes 1 exactly when the written result is 0. The overflow flag takes the carry out of an add, or the borrow of a subtract (set when `src1 < opb` unsigned). Opcodes 3 to 7 clear it. All other opcodes leave both flags unchanged.
- R4: Opcode 3 writes `src1 & opb`. Opcode 4 writes `src1 | opb`. Opcode 7 (move) writes `opb`.
- R5: Opcode 5 writes `src1` shifted left, and opcode 6 writes `src1` shifted right, by `opb[3:0]` bits. Both shifts fill with zeros. Shift amounts of 0 to 15 are defined.
- R6: Opcode 8 sets the stage counter to 0. Opcode 9 adds `imm[7:0]` to it and opcode 10 subtracts `imm[7:0]` from it. Both wrap modulo 256.
- R7: Opcode 11 is an absolute jump. The target is `imm[10:0]` when `use_imm` is 1, and the low 11 bits of register `src1_sel` (a word address) otherwise. Condition code 0 always jumps. Code 1 jumps when the zero flag is 1. Code 2 jumps when the overflow flag is 1. Code 3 never jumps.
- R8: Opcode 12 compares R0 (unsigned) with `imm`. Condition code 0 branches when R0 < imm, code 1 branches when R0 >= imm, and codes 2 and 3 never branch. A taken relative branch goes to `cur_pc` plus the signed byte step `step_bytes` shifted right arithmetically by 2, modulo 2^11.
- R9: Opcode 13 compares the stage counter (unsigned) with `imm[7:0]`. Condition code 0 branches when the counter is less, code 1 when it is less or equal, and code 2 when it is greater or equal. Code 3 never branches. The target is computed as in R8.
- R10: With `op_valid` high and no branch taken, `next_pc` is `cur_pc + 1` modulo 2^11 and `branch_taken` is 0. Opcode 0 and opcodes 14 and 15 change no state. With `op_valid` low, `next_pc` equals `cur_pc`, `branch_taken` is 0 and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation code |
| cond | input | 2 | Branch condition code |
| dst_sel | input | 2 | Destination register index |
| src1_sel | input | 2 | First source register index, also the jump register |
| src2_sel | input | 2 | Second source register index |
| use_imm | input | 1 | Use `imm` as second operand or jump target |
| imm | input | 16 | Immediate operand, threshold or target |
| step_bytes | input | 13 | Signed relative branch step in bytes |
| cur_pc | input | 11 | Word address of the current operation |
| next_pc | output | 11 | Word address of the next operation |
| branch_taken | output | 1 | The current operation redirects the flow |
| regs_out | output | 64 | Register file, R0 in the low 16 bits |
| stage_cnt | output | 8 | Loop stage counter |
| zero_flag | output | 1 | Last ALU result was zero |
| ovf_flag | output | 1 | Last ALU carry or borrow |

## Verification
The bench builds the core with its default parameters: 16-bit data, four registers, an 8-bit stage counter, an 11-bit program counter and a 13-bit byte step. An 8-bit counter lets a single increment or decrement cross the wrap point. An 11-bit program counter lets a negative step from address 0, or a large positive step, wrap the branch target, and lets a register-held jump target lose its upper bits. With 16-bit data, add carry and subtract borrow can be reached with one immediate each.

// File: rtl/cop_exec_core.sv
module cop_exec_core #(
  parameter int DATA_W  = 16,
  parameter int NREG    = 4,
  parameter int STAGE_W = 8,
  parameter int PC_W    = 11,
  parameter int STEP_W  = 13,
  localparam int RSEL_W = $clog2(NREG),
  localparam int SH_W   = $clog2(DATA_W)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   op_valid,
  input  logic [3:0]             op_code,
  input  logic [1:0]             cond,
  input  logic [RSEL_W-1:0]      dst_sel,
  input  logic [RSEL_W-1:0]      src1_sel,
  input  logic [RSEL_W-1:0]      src2_sel,
  input  logic                   use_imm,
  input  logic [DATA_W-1:0]      imm,
  input  logic [STEP_W-1:0]      step_bytes,
  input  logic [PC_W-1:0]        cur_pc,
  output logic [PC_W-1:0]        next_pc,
  output logic                   branch_taken,
  output logic [NREG*DATA_W-1:0] regs_out,
  output logic [STAGE_W-1:0]     stage_cnt,
  output logic                   zero_flag,
  output logic                   ovf_flag
);

  localparam logic [3:0] OP_ADD = 4'd1, OP_SUB = 4'd2, OP_AND = 4'd3, OP_OR = 4'd4,
                         OP_LSH = 4'd5, OP_RSH = 4'd6, OP_MOV = 4'd7, OP_SRST = 4'd8,
                         OP_SINC = 4'd9, OP_SDEC = 4'd10, OP_JMP = 4'd11, OP_JR0 = 4'd12,
                         OP_JSTG = 4'd13;

  logic [DATA_W-1:0] rf [NREG];
  logic [DATA_W-1:0] opa, opb, alu_res;
  logic              alu_c, is_alu, take;

  assign opa = rf[src1_sel];
  assign opb = use_imm ? imm : rf[src2_sel];

  always_comb begin
    is_alu  = 1'b1;
    alu_c   = 1'b0;
    alu_res = '0;
    case (op_code)
      OP_ADD:  {alu_c, alu_res} = {1'b0, opa} + {1'b0, opb};
      OP_SUB:  {alu_c, alu_res} = {1'b0, opa} - {1'b0, opb};
      OP_AND:  alu_res = opa & opb;
      OP_OR:   alu_res = opa | opb;
      OP_LSH:  alu_res = opa << opb[SH_W-1:0];
      OP_RSH:  alu_res = opa >> opb[SH_W-1:0];
      OP_MOV:  alu_res = opb;
      default: is_alu = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
      stage_cnt <= '0;
      zero_flag <= 1'b0;
      ovf_flag  <= 1'b0;
    end else if (op_valid) begin
      if (is_alu) begin
        rf[dst_sel] <= alu_res;
        zero_flag   <= (alu_res == '0);
        ovf_flag    <= alu_c;
      end
      case (op_code)
        OP_SRST: stage_cnt <= '0;
        OP_SINC: stage_cnt <= stage_cnt + imm[STAGE_W-1:0];
        OP_SDEC: stage_cnt <= stage_cnt - imm[STAGE_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_regs
    assign regs_out[g*DATA_W +: DATA_W] = rf[g];
  end

  logic signed [STEP_W-1:0] step_s, step_w;
  logic [PC_W-1:0]          rel_tgt, abs_tgt;
  logic [STAGE_W-1:0]       thr_s;

  assign step_s  = step_bytes;
  assign step_w  = step_s >>> 2;
  assign rel_tgt = cur_pc + PC_W'(step_w);
  assign abs_tgt = use_imm ? imm[PC_W-1:0] : opa[PC_W-1:0];
  assign thr_s   = imm[STAGE_W-1:0];

  always_comb begin
    take = 1'b0;
    case (op_code)
      OP_JMP:  take = (cond == 2'd0) || (cond == 2'd1 && zero_flag) || (cond == 2'd2 && ovf_flag);
      OP_JR0:  take = (cond == 2'd0 && rf[0] < imm) || (cond == 2'd1 && rf[0] >= imm);
      OP_JSTG: take = (cond == 2'd0 && stage_cnt < thr_s) || (cond == 2'd1 && stage_cnt <= thr_s) ||
                      (cond == 2'd2 && stage_cnt >= thr_s);
      default: take = 1'b0;
    endcase
  end

  assign branch_taken = op_valid && take;
  assign next_pc = !op_valid    ? cur_pc :
                   !take        ? cur_pc + 1'b1 :
                   (op_code == OP_JMP) ? abs_tgt : rel_tgt;

endmodule

// File: rtl/cop_exec_core_chk.sv
module cop_exec_core_chk #(
  parameter int DATA_W  = 16,
  parameter int NREG    = 4,
  parameter int STAGE_W = 8,
  parameter int PC_W    = 11,
  parameter int STEP_W  = 13,
  localparam int RSEL_W = $clog2(NREG)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   op_valid,
  input logic [3:0]             op_code,
  input logic [1:0]             cond,
  input logic [RSEL_W-1:0]      dst_sel,
  input logic [RSEL_W-1:0]      src1_sel,
  input logic [RSEL_W-1:0]      src2_sel,
  input logic                   use_imm,
  input logic [DATA_W-1:0]      imm,
  input logic [STEP_W-1:0]      step_bytes,
  input logic [PC_W-1:0]        cur_pc,
  input logic [PC_W-1:0]        next_pc,
  input logic                   branch_taken,
  input logic [NREG*DATA_W-1:0] regs_out,
  input logic [STAGE_W-1:0]     stage_cnt,
  input logic                   zero_flag,
  input logic                   ovf_flag
);

  logic alu_op;
  assign alu_op = op_valid && op_code >= 4'd1 && op_code <= 4'd7;

  AST_STAGE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd8) |=> stage_cnt == '0); // R6

  AST_FLAGS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !alu_op |=> ($stable(zero_flag) && $stable(ovf_flag))); // R3

  AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    alu_op |=> zero_flag == (regs_out[$past(dst_sel)*DATA_W +: DATA_W] == '0)); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> (next_pc == cur_pc && !branch_taken)); // R10

  AST_IDLE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(regs_out) && $stable(stage_cnt))); // R10

  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !branch_taken) |-> next_pc == PC_W'(cur_pc + 1'b1)); // R10

  AST_JUMP_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd11 && cond == 2'd3) |-> !branch_taken); // R7

endmodule

bind cop_exec_core cop_exec_core_chk #(
  .DATA_W(DATA_W), .NREG(NREG), .STAGE_W(STAGE_W), .PC_W(PC_W), .STEP_W(STEP_W)
) u_chk (.*);

// File: tb/tb_cop_exec_core.sv
`timescale 1ns/1ps
module tb_cop_exec_core;
  logic        clk = 0, rst_n = 0, op_valid = 0, use_imm = 0;
  logic [3:0]  op_code = 0;
  logic [1:0]  cond = 0, dst_sel = 0, src1_sel = 0, src2_sel = 0;
  logic [15:0] imm = 0;
  logic [12:0] step_bytes = 0;
  logic [10:0] cur_pc = 0, next_pc;
  logic        branch_taken, zero_flag, ovf_flag;
  logic [63:0] regs_out;
  logic [7:0]  stage_cnt;

  always #2.5 clk = ~clk;

  cop_exec_core dut (.*);

  int checks = 0, fails = 0;
  int mr[4];
  int ms = 0, mz = 0, mo = 0;
  string last_tag = "R1";

  task automatic check(input string tag, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [79:0] model_state();
    return {16'(mr[3]), 16'(mr[2]), 16'(mr[1]), 16'(mr[0]), 8'(ms), 1'(mz), 1'(mo), 6'd0};
  endfunction

  function automatic logic [79:0] dut_state();
    return {regs_out, stage_cnt, zero_flag, ovf_flag, 6'd0};
  endfunction

  function automatic string tag_of(input int op, input bit v);
    if (!v) return "R10";
    case (op)
      1, 2:    return "R2 R3";
      3, 4, 7: return "R4 R3";
      5, 6:    return "R5 R3";
      8, 9, 10: return "R6";
      11:      return "R7";
      12:      return "R8";
      13:      return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic step(input int op, input int cd, input int d, input int s1, input int s2,
                      input bit ui, input int im, input int st, input int pc, input bit v);
    int a, b, r, c, tgt, sst, exp_pc;
    bit take, alu;
    @(negedge clk);
    check(last_tag, dut_state(), model_state());
    op_valid = v; op_code = 4'(op); cond = 2'(cd); dst_sel = 2'(d); src1_sel = 2'(s1);
    src2_sel = 2'(s2); use_imm = ui; imm = 16'(im); step_bytes = 13'(st); cur_pc = 11'(pc);
    #1;
    a = mr[s1]; b = ui ? (im & 16'hFFFF) : mr[s2];
    sst = st & 13'h1FFF; if (sst >= 4096) sst -= 8192;
    take = 0; tgt = 0; alu = 1; c = 0; r = 0;
    case (op)
      1: begin r = a + b; c = r >> 16; r &= 16'hFFFF; end
      2: begin c = (a < b); r = (a - b) & 16'hFFFF; end
      3: r = a & b;
      4: r = a | b;
      5: r = (a << (b & 15)) & 16'hFFFF;
      6: r = a >> (b & 15);
      7: r = b;
      default: alu = 0;
    endcase
    if (op == 11) begin
      take = (cd == 0) || (cd == 1 && mz == 1) || (cd == 2 && mo == 1);
      tgt = ui ? (im & 11'h7FF) : (mr[s1] & 11'h7FF);
    end else if (op == 12) begin
      take = (cd == 0 && mr[0] < (im & 16'hFFFF)) || (cd == 1 && mr[0] >= (im & 16'hFFFF));
      tgt = (pc + (sst >>> 2)) & 11'h7FF;
    end else if (op == 13) begin
      take = (cd == 0 && ms < (im & 255)) || (cd == 1 && ms <= (im & 255)) ||
             (cd == 2 && ms >= (im & 255));
      tgt = (pc + (sst >>> 2)) & 11'h7FF;
    end
    if (!v) begin take = 0; exp_pc = pc; end
    else exp_pc = take ? tgt : ((pc + 1) & 11'h7FF);
    check({tag_of(op, v) == "R10" ? "R10" : tag_of(op, v)}, {69'd0, next_pc}, {69'd0, 11'(exp_pc)});
    check(tag_of(op, v), {79'd0, branch_taken}, {79'd0, take});
    if (v) begin
      if (alu) begin mr[d] = r; mz = (r == 0); mo = c; end
      if (op == 8) ms = 0;
      if (op == 9) ms = (ms + (im & 255)) & 255;
      if (op == 10) ms = (ms - (im & 255)) & 255;
    end
    last_tag = tag_of(op, v);
  endtask

  initial begin
    #(5ns * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    foreach (mr[i]) mr[i] = 0;
    repeat (3) @(negedge clk);
    check("R1", dut_state(), 80'd0);
    rst_n = 1;
    // R2 R3: add carry into zero
    step(7, 0, 1, 0, 0, 1, 16'hFFFF, 0, 0, 1);
    step(1, 0, 2, 1, 0, 1, 1, 0, 1, 1);
    // R7: jump on overflow and on zero, flags survive stage ops
    step(9, 0, 0, 0, 0, 1, 3, 0, 2, 1);
    step(11, 2, 0, 0, 0, 1, 100, 0, 3, 1);
    step(11, 1, 0, 0, 0, 1, 200, 0, 100, 1);
    // R2 R3: subtract borrow
    step(2, 0, 3, 0, 0, 1, 1, 0, 200, 1);
    step(11, 1, 0, 0, 0, 1, 5, 0, 201, 1);
    step(11, 3, 0, 0, 0, 1, 5, 0, 202, 1);
    // R5: shift by register
    step(7, 0, 3, 0, 0, 1, 4, 0, 203, 1);
    step(5, 0, 1, 1, 3, 0, 0, 0, 204, 1);
    step(6, 0, 2, 1, 3, 0, 0, 0, 205, 1);
    step(5, 0, 2, 1, 0, 1, 15, 0, 206, 1);
    // R4
    step(3, 0, 0, 1, 2, 0, 0, 0, 207, 1);
    step(4, 0, 0, 3, 0, 1, 16'h1230, 0, 208, 1);
    // R6: wrap both ways
    step(8, 0, 0, 0, 0, 1, 0, 0, 209, 1);
    step(9, 0, 0, 0, 0, 1, 250, 0, 210, 1);
    step(9, 0, 0, 0, 0, 1, 10, 0, 211, 1);
    step(10, 0, 0, 0, 0, 1, 5, 0, 212, 1);
    // R9: boundary equal
    step(13, 1, 0, 0, 0, 1, 255, 16, 213, 1);
    step(13, 0, 0, 0, 0, 1, 255, 16, 217, 1);
    step(13, 2, 0, 0, 0, 1, 255, -8, 218, 1);
    // R8: boundary equal, negative step and wrap
    step(7, 0, 0, 0, 0, 1, 20, 0, 216, 1);
    step(12, 0, 0, 0, 0, 1, 20, 8, 217, 1);
    step(12, 1, 0, 0, 0, 1, 20, -8, 5, 1);
    step(12, 1, 0, 0, 0, 1, 20, -4, 0, 1);
    step(12, 0, 0, 0, 0, 1, 21, 4095, 2040, 1);
    // R7: register target keeps low 11 bits
    step(7, 0, 2, 0, 0, 1, 16'h0ABC, 0, 1, 1);
    step(11, 0, 0, 2, 0, 0, 0, 0, 2, 1);
    // R10: idle and nop, pc wrap
    step(1, 0, 1, 1, 1, 0, 0, 0, 2047, 0);
    step(0, 0, 1, 1, 1, 0, 0, 0, 2047, 1);
    step(15, 0, 1, 1, 1, 0, 0, 0, 10, 1);
    for (int n = 0; n < 4000; n++) begin
      int op = $urandom_range(0, 15);
      bit ui = $urandom_range(0, 1);
      int im = $urandom_range(0, 65535);
      if (op == 5 || op == 6) begin ui = 1; im = im & 15; end
      if ((op == 12 || op == 13) && $urandom_range(0, 3) == 0) im = (op == 12) ? mr[0] : ms;
      step(op, $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
           $urandom_range(0, 3), ui, im, $urandom_range(0, 8191), $urandom_range(0, 2047),
           $urandom_range(0, 9) != 0);
    end
    @(negedge clk);
    check(last_tag, dut_state(), model_state());
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule